// File: doc/BRIEF.md
# Booth-Recoded Carry-Save FIR Filter

This block is a direct-form finite impulse response filter with `ORDER+1` taps and no feedback path. It accepts one signed two's-complement sample on each cycle where `in_valid` is high. For each such sample it produces one full-precision filtered output, formed from the newest sample and the `ORDER` samples accepted before it. Cycles with `in_valid` low do not advance the filter and are ignored.

Each tap multiplies its sample by its coefficient using radix-4 modified Booth recoding of the sample. That gives `ceil(DATA_W/2)` partial products per tap instead of `DATA_W`. The partial products of all taps are not resolved one by one. They go through a single tree of 3:2 carry-save compressors, which leaves one sum vector and one carry vector. These two vectors are registered. A parallel-prefix carry-lookahead adder, built from generate `a&b` and propagate `a^b` terms, resolves them into the registered output.

The coefficients sit in a small register bank, written one tap at a time through a write port. A system normally writes the coefficients while the stream is idle and then feeds samples at any rate up to one per cycle.

Top module: `booth_fir`

## Requirements
- R1: For each accepted sample x[n], the output equals the sum over k = 0..ORDER of c[k]·x[n-k]. Here c[k] is the coefficient at write address k, and samples from before the last reset count as zero.
- R2: `out_valid` is high in exactly the cycles that come two clock edges after a cycle with `in_valid` high. Outputs appear in the order the samples were accepted, one output per sample.
- R3: In a cycle with `in_valid` low, the stored sample history does not change and `in_data` has no effect on any later output.
- R4: Samples and coefficients are signed two's complement. The output is `DATA_W+COEF_W+ceil(log2(ORDER+1))` bits wide and exact for every input, including all taps at the most negative sample and coefficient values.
- R5: A single sample of value 1 followed by zeros produces outputs c[0], c[1], ..., c[ORDER], then zeros.
- R6: When `coef_we` is high at a clock edge, `coef_wdata` is stored as c[`coef_addr`] and applies to samples accepted in later cycles. A write to an address of ORDER+1 or above changes no coefficient.
- R7: While `rst` is high at a clock edge, the sample history, `out_valid` and `out_data` are cleared to zero. The coefficients keep their values.
- R8: `out_data` keeps its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on `in_data` is accepted this cycle |
| in_data | input | DATA_W | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | ADDR_W | Tap index to write (0 = newest sample) |
| coef_wdata | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | `out_data` holds a new filtered result |
| out_data | output | ACC_W | Signed filtered result |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any check matters. They also assume a known level on `in_valid` and `coef_we` at every edge after that. The latency and hold checks only begin counting edges once reset has been released. The bench therefore starts in reset, drives every control input from the falling edge, and keeps both strobes at a defined 0 or 1 throughout. Coefficient writes are made only in cycles where no sample is accepted, so each expected output uses a single, well-defined coefficient set. Random stimulus draws its out-of-range write addresses from the unused codes of `coef_addr`.

// File: rtl/booth_fir.sv
module booth_fir #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ORDER  = 4,
  localparam int TAPS   = ORDER + 1,
  localparam int ADDR_W = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              coef_we,
  input  logic [ADDR_W-1:0] coef_addr,
  input  logic [COEF_W-1:0] coef_wdata,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);
  localparam int ND = (DATA_W + 1) / 2;
  localparam int XW = 2 * ND;
  localparam int R  = TAPS * (ND + 1);

  logic [ORDER-1:0][DATA_W-1:0] xline;
  logic [TAPS-1:0][COEF_W-1:0]  coef_q;
  logic [TAPS-1:0][DATA_W-1:0]  win;
  logic [ACC_W-1:0]             rows [R];
  logic [ACC_W-1:0]             red_s, red_c, s_q, c_q, cla_sum;
  logic                         v1;

  assign win = {xline, in_data};

  always_ff @(posedge clk)
    if (coef_we && ({1'b0, coef_addr} < (ADDR_W+1)'(TAPS)))
      coef_q[coef_addr] <= coef_wdata;

  // Booth radix-4 partial products, one correction row per tap for negations
  always_comb begin
    logic signed [XW-1:0]    xs;
    logic [XW:0]             xe;
    logic signed [ACC_W-1:0] ce;
    logic [ACC_W-1:0]        base, corr;
    logic [2:0]              trip;
    logic                    one, two, neg;
    for (int t = 0; t < R; t++) rows[t] = '0;
    for (int k = 0; k < TAPS; k++) begin
      xs   = XW'(signed'(win[k]));
      xe   = {xs, 1'b0};
      ce   = ACC_W'(signed'(coef_q[k]));
      corr = '0;
      for (int i = 0; i < ND; i++) begin
        trip = xe[2*i +: 3];
        one  = trip[1] ^ trip[0];
        two  = (trip == 3'b011) || (trip == 3'b100);
        neg  = trip[2] && (trip != 3'b111);
        base = one ? ce : (two ? (ce << 1) : '0);
        rows[k*(ND+1) + i] = (neg ? ~base : base) << (2*i);
        corr[2*i] = neg;
      end
      rows[k*(ND+1) + ND] = corr;
    end
  end

  // 3:2 carry-save reduction tree, level by level, down to two rows
  always_comb begin
    logic [ACC_W-1:0] lvl [R];
    logic [ACC_W-1:0] nxt [R];
    logic [ACC_W-1:0] a, b, c;
    int n, m;
    for (int t = 0; t < R; t++) lvl[t] = rows[t];
    n = R;
    for (int l = 0; l < R; l++) begin
      if (n > 2) begin
        for (int t = 0; t < R; t++) nxt[t] = '0;
        m = 0;
        for (int j = 0; j < R; j++) begin
          if (j < (n / 3) * 3) begin
            if (j % 3 == 0) begin
              a = lvl[j]; b = lvl[j+1]; c = lvl[j+2];
              nxt[m]   = a ^ b ^ c;
              nxt[m+1] = ((a & b) | (a & c) | (b & c)) << 1;
              m = m + 2;
            end
          end else if (j < n) begin
            nxt[m] = lvl[j];
            m = m + 1;
          end
        end
        for (int t = 0; t < R; t++) lvl[t] = nxt[t];
        n = m;
      end
    end
    red_s = lvl[0];
    red_c = lvl[1];
  end

  // Parallel-prefix carry-lookahead resolution of the registered pair
  always_comb begin
    logic [ACC_W-1:0] g, p, gp, pp, gn, pn;
    g  = s_q & c_q;
    p  = s_q ^ c_q;
    gp = g;
    pp = p;
    for (int d = 1; d < ACC_W; d = d * 2) begin
      gn = gp;
      pn = pp;
      for (int i = d; i < ACC_W; i++) begin
        gn[i] = gp[i] | (pp[i] & gp[i-d]);
        pn[i] = pp[i] & pp[i-d];
      end
      gp = gn;
      pp = pn;
    end
    cla_sum = p ^ {gp[ACC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xline     <= '0;
      s_q       <= '0;
      c_q       <= '0;
      v1        <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) begin
        xline[0] <= in_data;
        for (int k = 1; k < ORDER; k++) xline[k] <= xline[k-1];
        s_q <= red_s;
        c_q <= red_c;
      end
      if (v1) out_data <= cla_sum;
    end
  end
endmodule

// File: rtl/booth_fir_chk.sv
module booth_fir_chk #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ORDER  = 4,
  localparam int TAPS   = ORDER + 1,
  localparam int ADDR_W = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         coef_we,
  input logic [ADDR_W-1:0]            coef_addr,
  input logic                         out_valid,
  input logic [ACC_W-1:0]             out_data,
  input logic [ORDER-1:0][DATA_W-1:0] xline,
  input logic [TAPS-1:0][COEF_W-1:0]  coef_q
);
  logic [1:0] seen;
  logic       started;

  always_ff @(posedge clk) started <= 1'b1;

  always_ff @(posedge clk)
    if (rst) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (seen >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_reset_clears_R7: assert property (@(posedge clk)
    (started && $past(rst)) |-> (!out_valid && out_data == '0 && xline == '0));

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (rst)
    (seen >= 2'd1 && !out_valid) |-> $stable(out_data));

  assert_idle_history_R3: assert property (@(posedge clk) disable iff (rst)
    (seen >= 2'd1 && !$past(in_valid)) |-> $stable(xline));

  assert_bad_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (seen >= 2'd1 && $past(coef_we) && ({1'b0, $past(coef_addr)} >= (ADDR_W+1)'(TAPS)))
      |-> $stable(coef_q));
endmodule

bind booth_fir booth_fir_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ORDER(ORDER)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .coef_we(coef_we), .coef_addr(coef_addr),
  .out_valid(out_valid), .out_data(out_data), .xline(xline), .coef_q(coef_q));

// File: tb/booth_fir_tb_top.sv
module booth_fir_tb_top;
  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int ORDER  = 4;
  localparam int TAPS   = ORDER + 1;
  localparam int ADDR_W = $clog2(TAPS);
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              coef_we = 1'b0;
  logic [ADDR_W-1:0] coef_addr = '0;
  logic [COEF_W-1:0] coef_wdata = '0;
  logic              out_valid;
  logic [ACC_W-1:0]  out_data;

  booth_fir #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ORDER(ORDER)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cm [TAPS];
  int hist [TAPS];
  int exp_q [$];
  string tag_q [$];
  string cur_tag = "R1";
  logic iv_d1 = 1'b0, iv_d2 = 1'b0;
  logic [ACC_W-1:0] last_out = '0;
  int cycles = 0;
  int sent = 0, got = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int conv();
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += cm[k] * hist[k];
    return s;
  endfunction

  task automatic send(input int v);
    @(negedge clk);
    coef_we  = 1'b0;
    in_valid = 1'b1;
    in_data  = DATA_W'(v);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'($signed(DATA_W'(v)));
    exp_q.push_back(conv());
    tag_q.push_back(cur_tag);
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      coef_we  = 1'b0;
      in_valid = 1'b0;
      in_data  = DATA_W'($urandom);
    end
  endtask

  task automatic wcoef(input int addr, input int val);
    @(negedge clk);
    in_valid   = 1'b0;
    coef_we    = 1'b1;
    coef_addr  = ADDR_W'(addr);
    coef_wdata = COEF_W'(val);
    if (addr < TAPS) cm[addr] = int'($signed(COEF_W'(val)));
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic do_reset();
    idle(4);
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
    check(out_data == '0, "R7 out_data after reset", $signed(out_data), 0);
  endtask

  always @(posedge clk) begin
    iv_d1 <= in_valid;
    iv_d2 <= iv_d1;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      last_out = '0;
    end else begin
      check(out_valid == iv_d2, "R2 latency", out_valid, iv_d2);
      if (out_valid) begin
        got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 output with no pending sample", 1, 0);
        end else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check($signed(out_data) == e, {t, " filtered value"}, $signed(out_data), e);
        end
        last_out = out_data;
      end else begin
        check(out_data == last_out, "R8 hold while idle", $signed(out_data), $signed(last_out));
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < TAPS; k++) begin cm[k] = 0; hist[k] = 0; end
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R7 initial reset state", $signed(out_data), 0);

    wcoef(0, 3); wcoef(1, -5); wcoef(2, 7); wcoef(3, -128); wcoef(4, 127);
    wcoef(6, 55);
    wcoef(5, -1);
    cur_tag = "R5/R6";
    send(1);
    for (int i = 0; i < TAPS + 1; i++) send(0);

    cur_tag = "R3";
    for (int i = 0; i < 12; i++) begin
      send(100);
      idle(i % 4);
    end

    do_reset();
    cur_tag = "R7 history cleared, coefficients kept";
    send(-1);
    for (int i = 0; i < TAPS; i++) send(0);

    for (int k = 0; k < TAPS; k++) wcoef(k, -128);
    cur_tag = "R4 most negative";
    for (int i = 0; i < TAPS + 2; i++) send(-128);
    for (int k = 0; k < TAPS; k++) wcoef(k, (k % 2 == 0) ? 127 : -128);
    cur_tag = "R4 alternating sign";
    for (int i = 0; i < 2 * TAPS; i++) send((i % 2 == 0) ? -128 : 127);

    for (int k = 0; k < TAPS; k++) wcoef(k, int'($urandom_range(0, 255)) - 128);
    cur_tag = "R1 random";
    for (int i = 0; i < 3000; i++) begin
      send(int'($urandom_range(0, 255)) - 128);
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
      if (i % 500 == 499) begin
        idle(1);
        wcoef(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)) - 128);
      end
    end
    idle(6);
    check(exp_q.size() == 0, "R2 every sample produced an output", exp_q.size(), 0);
    check(got == sent, "R2 output count", got, sent);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule